// File: doc/BRIEF.md
# Polling Receiver Bit-Period Checker

This block sits behind a radio demodulator and decides whether the bit stream it produces comes from a real transmitter before a host is woken. After enable it waits out a programmable startup time, because the demodulator output is meaningless then. It then measures each interval between edges of the demodulator bit, counted in ticks of an extended clock enable. An interval that falls inside a programmable window counts as a good bit. An interval that is too short, or one that runs to the upper limit, sends the block to sleep for a programmable time. After sleep the startup sequence runs again, which forms the polling loop.

Once the required number of consecutive good intervals has been seen, the block latches receiving mode. In receiving mode it drives the synchronized, tick-sampled demodulator bit on its data output. A host leaves receiving mode only with an explicit return-to-polling command. The demodulator bit passes through a two-flop synchronizer and is sampled only on ticks, so every data output transition lines up with a tick.

Top module: `bitchk_poller`

## Requirements
- R1: While `en` is low the block goes to OFF (mode 0) on the next clock, with `data_out` at 1 and both `chk_pass` and `chk_fail` at 0; reset gives the same state.
- R2: With `en` high, OFF moves to STARTUP (mode 1) on the next clock. STARTUP lasts `startup_len` ticks and then moves to CHECK (mode 2). Demodulator activity during STARTUP has no effect on the checking that follows.
- R3: In CHECK, the first sampled edge only starts the measurement and is not judged, however short the time since CHECK was entered.
- R4: An interval of P ticks between two sampled edges passes when `lim_lo` <= P < `lim_hi`; both boundary values 14 and 23 pass with the default limits 14 and 24.
- R5: An edge that ends an interval of fewer than `lim_lo` ticks fails the check: mode becomes SLEEP (mode 4) and `chk_fail` becomes 1 on that tick.
- R6: When the interval count reaches `lim_hi` the check fails on that tick, whether or not an edge arrives in the same tick.
- R7: After `need_bits` consecutive passing intervals the block enters RECV (mode 3) on the tick of the last passing edge and sets `chk_pass` to 1.
- R8: RECV is held whatever the demodulator does, until `resume` is high, which moves the block to STARTUP on the next clock.
- R9: In RECV, `data_out` equals the last tick-sampled, synchronized demodulator bit and changes only on a tick; in every other mode it is 1.
- R10: SLEEP lasts `sleep_len` ticks and then returns to STARTUP; `chk_pass` and `chk_fail` are both cleared when CHECK is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Extended clock enable, one clock wide |
| en | input | 1 | Block enable |
| demod_in | input | 1 | Raw demodulator bit, asynchronous |
| lim_lo | input | CNT_W | Shortest passing interval in ticks |
| lim_hi | input | CNT_W | Interval length in ticks that fails |
| need_bits | input | NB_W | Passing intervals required for RECV |
| startup_len | input | TMR_W | STARTUP duration in ticks |
| sleep_len | input | TMR_W | SLEEP duration in ticks |
| resume | input | 1 | Return from RECV to polling |
| mode | output | 3 | 0 OFF, 1 STARTUP, 2 CHECK, 3 RECV, 4 SLEEP |
| data_out | output | 1 | Sampled data in RECV, 1 elsewhere |
| chk_pass | output | 1 | Last check reached RECV |
| chk_fail | output | 1 | Last check failed |

## Verification
Mode changes caused by `en` or `resume` are due one clock after the input changes. Results of checking are due on the clock edge where `tick` is high, and the bench reads them at the falling edge that follows that tick. The demodulator input is changed right after a tick, at least three clocks before the next one, so the two-flop synchronizer has settled when the next tick samples it. A data change is therefore checked twice: once two clocks after the input moves, where it must not yet appear, and once right after the next tick, where it must.

// File: rtl/bitchk_poller.sv
module bitchk_poller #(
  parameter int CNT_W = 8,
  parameter int NB_W  = 4,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             demod_in,
  input  logic [CNT_W-1:0] lim_lo,
  input  logic [CNT_W-1:0] lim_hi,
  input  logic [NB_W-1:0]  need_bits,
  input  logic [TMR_W-1:0] startup_len,
  input  logic [TMR_W-1:0] sleep_len,
  input  logic             resume,
  output logic [2:0]       mode,
  output logic             data_out,
  output logic             chk_pass,
  output logic             chk_fail
);
  localparam int PER_W = CNT_W + 1;

  typedef enum logic [2:0] {
    M_OFF = 3'd0, M_START = 3'd1, M_CHECK = 3'd2, M_RECV = 3'd3, M_SLEEP = 3'd4
  } mode_t;

  mode_t            st;
  logic             s0, s1, smp, armed;
  logic [CNT_W-1:0] cnt;
  logic [NB_W-1:0]  good;
  logic [TMR_W-1:0] tmr;

  wire              edge_t   = tick && (s1 != smp);
  wire [PER_W-1:0]  per      = {1'b0, cnt} + PER_W'(1);
  wire              too_long = per >= {1'b0, lim_hi};
  wire              too_short = per < {1'b0, lim_lo};
  wire [TMR_W:0]    tnext    = {1'b0, tmr} + (TMR_W+1)'(1);
  wire              st_done  = tnext >= {1'b0, startup_len};
  wire              sl_done  = tnext >= {1'b0, sleep_len};
  wire [NB_W:0]     gnext    = {1'b0, good} + (NB_W+1)'(1);
  wire              enough   = gnext >= {1'b0, need_bits};

  assign mode     = st;
  assign data_out = (st == M_RECV) ? smp : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= M_OFF;
      s0       <= 1'b1;
      s1       <= 1'b1;
      smp      <= 1'b1;
      armed    <= 1'b0;
      cnt      <= '0;
      good     <= '0;
      tmr      <= '0;
      chk_pass <= 1'b0;
      chk_fail <= 1'b0;
    end else begin
      s0 <= demod_in;
      s1 <= s0;
      if (tick) smp <= s1;
      if (!en) begin
        st       <= M_OFF;
        tmr      <= '0;
        chk_pass <= 1'b0;
        chk_fail <= 1'b0;
      end else begin
        case (st)
          M_OFF: begin
            st  <= M_START;
            tmr <= '0;
          end
          M_START: if (tick) begin
            if (st_done) begin
              st       <= M_CHECK;
              tmr      <= '0;
              cnt      <= '0;
              good     <= '0;
              armed    <= 1'b0;
              chk_pass <= 1'b0;
              chk_fail <= 1'b0;
            end else begin
              tmr <= tnext[TMR_W-1:0];
            end
          end
          M_CHECK: if (tick) begin
            if (too_long) begin
              st       <= M_SLEEP;
              chk_fail <= 1'b1;
              tmr      <= '0;
            end else if (edge_t) begin
              cnt <= '0;
              if (!armed) begin
                armed <= 1'b1;
              end else if (too_short) begin
                st       <= M_SLEEP;
                chk_fail <= 1'b1;
                tmr      <= '0;
              end else if (enough) begin
                st       <= M_RECV;
                chk_pass <= 1'b1;
              end else begin
                good <= gnext[NB_W-1:0];
              end
            end else begin
              cnt <= per[CNT_W-1:0];
            end
          end
          M_RECV: if (resume) begin
            st  <= M_START;
            tmr <= '0;
          end
          M_SLEEP: if (tick) begin
            if (sl_done) begin
              st  <= M_START;
              tmr <= '0;
            end else begin
              tmr <= tnext[TMR_W-1:0];
            end
          end
          default: st <= M_OFF;
        endcase
      end
    end
  end

  // R1: disable forces OFF on the next clock
  a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (mode == 3'd0));

  // R5 / R6: a failure flag only rises when leaving CHECK for SLEEP
  a_r5_fail_from_check: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_fail) |-> ($past(mode) == 3'd2 && mode == 3'd4));

  // R7: RECV is entered from CHECK only on a tick
  a_r7_recv_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && $past(mode) == 3'd2) |-> $past(tick));

  // R9: data output moves only on a tick while in RECV
  a_r9_data_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && $past(mode) == 3'd3 && !$past(tick)) |-> $stable(data_out));

  // R9: outside RECV the data output idles high
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd3) |-> data_out);

  // R8: RECV is only left by resume or disable
  a_r8_recv_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 3'd3 && mode != 3'd3) |-> ($past(resume) || !$past(en)));
endmodule

// File: tb/bitchk_poller_tb.sv
module bitchk_poller_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, tick, en, d, resume;
  logic [7:0] lim_lo, lim_hi, startup_len, sleep_len;
  logic [3:0] need_bits;
  logic [2:0] mode;
  logic       data_out, chk_pass, chk_fail;
  int         checks = 0;
  int         errors = 0;
  int         cyc = 0;

  always #10 clk = ~clk;

  bitchk_poller dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .demod_in(d),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .need_bits(need_bits),
    .startup_len(startup_len), .sleep_len(sleep_len), .resume(resume),
    .mode(mode), .data_out(data_out), .chk_pass(chk_pass), .chk_fail(chk_fail)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tk();
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic tks(int n);
    for (int i = 0; i < n; i++) tk();
  endtask

  task automatic edge_after(int p);
    tks(p - 1);
    d = ~d;
    tk();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R9 reset data", data_out, 1);
    chk("R1 reset flags", {chk_pass, chk_fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_startup();
    en = 1'b1;
    @(negedge clk);
    chk("R2 off to startup", mode, 1);
    for (int i = 0; i < 4; i++) begin
      d = ~d;
      tk();
    end
    chk("R2 still in startup", mode, 1);
    d = ~d;
    tk();
    chk("R2 startup to check", mode, 2);
    edge_after(3);
    chk("R3 first edge only arms", mode, 2);
    chk("R3 no fail on arm", chk_fail, 0);
  endtask

  task automatic t_pass();
    for (int i = 0; i < 3; i++) begin
      edge_after(16);
      chk("R7 counting good bits", mode, 2);
    end
    edge_after(16);
    chk("R7 enter recv", mode, 3);
    chk("R7 pass flag", chk_pass, 1);
  endtask

  task automatic t_recv();
    logic old;
    chk("R9 data follows input", data_out, d);
    old = d;
    d = ~d;
    repeat (2) @(negedge clk);
    chk("R9 data waits for tick", data_out, old);
    tk();
    chk("R9 data after tick", data_out, d);
    for (int i = 0; i < 3; i++) edge_after(2);
    chk("R8 recv held on short bits", mode, 3);
    tks(30);
    chk("R8 recv held on silence", mode, 3);
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    chk("R8 resume to startup", mode, 1);
    chk("R9 idle high outside recv", data_out, 1);
  endtask

  task automatic t_short();
    tks(5);
    chk("R10 pass cleared on check entry", chk_pass, 0);
    edge_after(2);
    edge_after(16);
    chk("R4 period 16 passes", mode, 2);
    edge_after(13);
    chk("R5 short period to sleep", mode, 4);
    chk("R5 fail flag", chk_fail, 1);
  endtask

  task automatic t_sleep();
    tks(5);
    chk("R10 sleep still running", mode, 4);
    tk();
    chk("R10 sleep to startup", mode, 1);
    tks(5);
    chk("R10 check again", mode, 2);
    chk("R10 fail cleared on check entry", chk_fail, 0);
  endtask

  task automatic t_long();
    edge_after(1);
    tks(23);
    chk("R6 count 23 no fail", mode, 2);
    tk();
    chk("R6 count 24 fails", mode, 4);
    chk("R6 fail flag", chk_fail, 1);
  endtask

  task automatic t_bounds();
    tks(6);
    chk("R10 back to startup", mode, 1);
    tks(5);
    edge_after(1);
    edge_after(14);
    chk("R4 period 14 passes", mode, 2);
    edge_after(23);
    chk("R4 period 23 passes", mode, 2);
    edge_after(14);
    edge_after(23);
    chk("R4 boundary periods reach recv", mode, 3);
  endtask

  task automatic t_edge24();
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    tks(5);
    edge_after(1);
    edge_after(24);
    chk("R6 edge at limit fails", mode, 4);
  endtask

  task automatic t_disable();
    en = 1'b0;
    @(negedge clk);
    chk("R1 disable to off", mode, 0);
    chk("R1 flags cleared", {chk_pass, chk_fail}, 0);
    chk("R9 data high when off", data_out, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; en = 1'b0; d = 1'b1; resume = 1'b0;
    lim_lo = 8'd14; lim_hi = 8'd24; need_bits = 4'd4;
    startup_len = 8'd5; sleep_len = 8'd6;
    t_reset();
    t_startup();
    t_pass();
    t_recv();
    t_short();
    t_sleep();
    t_long();
    t_bounds();
    t_edge24();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule